// File: doc/BRIEF.md
# Debug Register Window to Wishbone Bridge

This block sits on a simple request/acknowledge debug bus and opens a three-register window onto a 64-bit Wishbone system bus. A debug host sets a bus address and a control word. It then reaches memory through a data port: a debug read of the port fetches the word at the current bus address, and a debug write of the port stores a word there. The write uses the byte lanes named in the control word.

When auto-increment is enabled in the control word, the bus address moves forward after every data-port access. A host can then walk through consecutive memory with repeated data-port accesses and no address writes in between.

The debug side follows a plain request/acknowledge rule, which stands in for valid/ready. The requester raises `dbg_req` with the address, direction and write data, and holds all of them until `dbg_ack` is seen. `dbg_ack` is high for exactly one cycle, and read data is valid in that cycle. Back-pressure comes only from the bridge: a data-port access stalls for as long as the Wishbone slave withholds its acknowledge. Register accesses finish in one cycle.

Top module: `dbg_wb_bridge`

## Requirements
- R1: After reset the bus address and control registers read as zero, `wb_cyc`/`wb_stb` are low and `dbg_ack` is low.
- R2: Debug index 0 is the bus address register. A 64-bit debug write to it is read back unchanged by a later debug read of index 0.
- R3: Debug index 2 is the control register. A 64-bit debug write to it is read back unchanged by a later debug read of index 2.
- R4: A debug read of index 1 starts a Wishbone read (`wb_we`=0) at the current bus address. The word on `wb_dat_i` at the Wishbone acknowledge is returned on `dbg_rdata` while `dbg_ack` is high.
- R5: A debug write of index 1 starts a Wishbone write (`wb_we`=1) at the current bus address, with `wb_dat_o` equal to the debug write data and `wb_sel` equal to control bits 7:0 (bit n enables byte n, bits 8n+7:8n).
- R6: For a data-port access, `dbg_ack` is high in the cycle after the cycle in which `wb_cyc` and `wb_ack` are both high, and never while `wb_cyc` is high.
- R7: Once raised, `wb_cyc` and `wb_stb` stay high, and `wb_adr`, `wb_we`, `wb_sel` and `wb_dat_o` stay stable, until the cycle in which `wb_ack` is sampled high.
- R8: `dbg_ack` is a single-cycle pulse, one per request.
- R9: When control bit 10 is 1, each completed data-port access adds 1 << (control bits 10:9) bytes to the bus address, so control 0x7FF steps by 8 and 0x40F by 4. When bit 10 is 0 the address does not change.
- R10: Debug index 3 is unused. A read of it returns zero, and a write to it changes neither the address nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dbg_req | input | 1 | Debug request, held until acknowledged |
| dbg_wr | input | 1 | 1 = write, 0 = read |
| dbg_addr | input | 2 | Register index |
| dbg_wdata | input | 64 | Debug write data |
| dbg_rdata | output | 64 | Debug read data, valid with `dbg_ack` |
| dbg_ack | output | 1 | One-cycle completion pulse |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_adr | output | 64 | Wishbone byte address |
| wb_dat_o | output | 64 | Wishbone write data |
| wb_sel | output | 8 | Wishbone byte selects |
| wb_dat_i | input | 64 | Wishbone read data |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
Data-port reads are run back to back with auto-increment at size 8, from a memory filled with a distinct word per address. A wrong address step, or a missing step, then returns the wrong word. A partial-lane write at step 4 is followed by a non-incrementing read-back. This separates correct byte-lane merging from full-word writes and shows that the address holds still when bit 10 is clear. The Wishbone slave's wait is varied between short and long stalls to show that the debug acknowledge tracks the bus acknowledge rather than a fixed delay. Writes to the unused index are followed by read-backs of both registers to expose any stray decode.

// File: rtl/dbgwb_pkg.sv
package dbgwb_pkg;
  localparam int unsigned IDX_W = 2;
  localparam logic [IDX_W-1:0] IDX_ADDR = 2'd0;
  localparam logic [IDX_W-1:0] IDX_DATA = 2'd1;
  localparam logic [IDX_W-1:0] IDX_CTRL = 2'd2;

  // Control word fields
  localparam int unsigned CTRL_INC_BIT = 10;
  localparam int unsigned CTRL_SIZE_HI = 10;
  localparam int unsigned CTRL_SIZE_LO = 9;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS  = 2'd1,
    ST_ACK  = 2'd2
  } br_state_e;
endpackage

// File: rtl/dbgwb_regs.sv
module dbgwb_regs
  import dbgwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr_en,
  input  logic              wr_ctrl_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step_en,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] ctrl_q
);
  localparam int unsigned SZ_W = CTRL_SIZE_HI - CTRL_SIZE_LO + 1;

  logic [SZ_W-1:0]   size_f;
  logic [ADDR_W-1:0] step;

  assign size_f = ctrl_q[CTRL_SIZE_HI:CTRL_SIZE_LO];

  always_comb begin
    step = '0;
    if (ctrl_q[CTRL_INC_BIT]) step = ADDR_W'(1) << size_f;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_addr_en)   addr_q <= ADDR_W'(wdata);
      else if (step_en) addr_q <= addr_q + step;
      if (wr_ctrl_en)   ctrl_q <= wdata;
    end
  end
endmodule

// File: rtl/dbgwb_wb_master.sv
module dbgwb_wb_master #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              we_in,
  input  logic [ADDR_W-1:0] adr_in,
  input  logic [DATA_W-1:0] dat_in,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic              wb_ack,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic [SEL_W-1:0]  wb_sel,
  output logic              done
);
  assign done = wb_cyc & wb_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_cyc   <= 1'b0;
      wb_stb   <= 1'b0;
      wb_we    <= 1'b0;
      wb_adr   <= '0;
      wb_dat_o <= '0;
      wb_sel   <= '0;
    end else if (done) begin
      wb_cyc <= 1'b0;
      wb_stb <= 1'b0;
    end else if (start && !wb_cyc) begin
      wb_cyc   <= 1'b1;
      wb_stb   <= 1'b1;
      wb_we    <= we_in;
      wb_adr   <= adr_in;
      wb_dat_o <= dat_in;
      wb_sel   <= sel_in;
    end
  end
endmodule

// File: rtl/dbg_wb_bridge.sv
module dbg_wb_bridge
  import dbgwb_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned SEL_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dbg_req,
  input  logic              dbg_wr,
  input  logic [IDX_W-1:0]  dbg_addr,
  input  logic [DATA_W-1:0] dbg_wdata,
  output logic [DATA_W-1:0] dbg_rdata,
  output logic              dbg_ack,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic [SEL_W-1:0]  wb_sel,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic              wb_ack
);
  br_state_e         state;
  logic              accept;
  logic              hit_data;
  logic              wr_addr_en;
  logic              wr_ctrl_en;
  logic              bus_done;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] reg_rd;
  logic [DATA_W-1:0] rdata_q;

  assign accept     = (state == ST_IDLE) && dbg_req;
  assign hit_data   = accept && (dbg_addr == IDX_DATA);
  assign wr_addr_en = accept && dbg_wr && (dbg_addr == IDX_ADDR);
  assign wr_ctrl_en = accept && dbg_wr && (dbg_addr == IDX_CTRL);

  always_comb begin
    unique case (dbg_addr)
      IDX_ADDR: reg_rd = DATA_W'(addr_q);
      IDX_CTRL: reg_rd = ctrl_q;
      default:  reg_rd = '0;
    endcase
  end

  dbgwb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_addr_en (wr_addr_en),
    .wr_ctrl_en (wr_ctrl_en),
    .wdata      (dbg_wdata),
    .step_en    (bus_done),
    .addr_q     (addr_q),
    .ctrl_q     (ctrl_q)
  );

  dbgwb_wb_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
    .clk      (clk),
    .rst      (rst),
    .start    (hit_data),
    .we_in    (dbg_wr),
    .adr_in   (addr_q),
    .dat_in   (dbg_wdata),
    .sel_in   (ctrl_q[SEL_W-1:0]),
    .wb_ack   (wb_ack),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_adr   (wb_adr),
    .wb_dat_o (wb_dat_o),
    .wb_sel   (wb_sel),
    .done     (bus_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      rdata_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (hit_data) begin
            state <= ST_BUS;
          end else if (accept) begin
            state   <= ST_ACK;
            rdata_q <= dbg_wr ? '0 : reg_rd;
          end
        end
        ST_BUS: begin
          if (bus_done) begin
            state   <= ST_ACK;
            rdata_q <= wb_we ? '0 : wb_dat_i;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign dbg_ack   = (state == ST_ACK);
  assign dbg_rdata = rdata_q;
endmodule

// File: rtl/dbgwb_checker.sv
module dbgwb_checker #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned SEL_W = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              dbg_ack,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_we,
  input logic              wb_ack,
  input logic [ADDR_W-1:0] wb_adr,
  input logic [DATA_W-1:0] wb_dat_o,
  input logic [SEL_W-1:0]  wb_sel,
  input logic [SEL_W-1:0]  ctrl_sel
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!wb_cyc && !dbg_ack));

  assert_sel_from_ctrl_R5: assert property (@(posedge clk) disable iff (rst)
    wb_cyc |-> (wb_sel == ctrl_sel));

  assert_ack_follows_bus_R6: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_ack) |=> dbg_ack);

  assert_no_ack_in_bus_R6: assert property (@(posedge clk) disable iff (rst)
    wb_cyc |-> !dbg_ack);

  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && !wb_ack) |=> (wb_cyc && wb_stb && $stable(wb_adr) &&
      $stable(wb_we) && $stable(wb_sel) && $stable(wb_dat_o)));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    dbg_ack |=> !dbg_ack);
endmodule

bind dbg_wb_bridge dbgwb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk      (clk),
  .rst      (rst),
  .dbg_ack  (dbg_ack),
  .wb_cyc   (wb_cyc),
  .wb_stb   (wb_stb),
  .wb_we    (wb_we),
  .wb_ack   (wb_ack),
  .wb_adr   (wb_adr),
  .wb_dat_o (wb_dat_o),
  .wb_sel   (wb_sel),
  .ctrl_sel (ctrl_q[SEL_W-1:0])
);

// File: tb/dbg_wb_bridge_bench.sv
module dbg_wb_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dbg_req = 1'b0;
  logic        dbg_wr = 1'b0;
  logic [1:0]  dbg_addr = '0;
  logic [63:0] dbg_wdata = '0;
  logic [63:0] dbg_rdata;
  logic        dbg_ack;
  logic        wb_cyc, wb_stb, wb_we;
  logic [63:0] wb_adr, wb_dat_o;
  logic [7:0]  wb_sel;
  logic [63:0] wb_dat_i = '0;
  logic        wb_ack = 1'b0;

  int n_run = 0;
  int n_fail = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  // slave model state
  logic [63:0] mem [16];
  int          slv_wait = 2;
  int          slv_cnt = 0;
  int          slv_ack_cyc = 0;
  logic [63:0] seen_adr, seen_dat;
  logic [7:0]  seen_sel;
  logic        seen_we;
  bit          unstable = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  dbg_wb_bridge u_dbg_wb_bridge (
    .clk(clk), .rst(rst), .dbg_req(dbg_req), .dbg_wr(dbg_wr),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .dbg_ack(dbg_ack), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_o(wb_dat_o), .wb_sel(wb_sel),
    .wb_dat_i(wb_dat_i), .wb_ack(wb_ack)
  );

  function automatic logic [63:0] init_word(int i);
    return 64'h0101_0101_0101_0101 * 64'(i + 1) ^ 64'hF000_0000_0000_000F;
  endfunction

  // Wishbone slave: acks after slv_wait cycles of cyc&stb
  always @(negedge clk) begin
    if (rst) begin
      wb_ack <= 1'b0;
      slv_cnt = 0;
    end else if (wb_cyc && wb_stb && !wb_ack) begin
      if (slv_cnt == 0) begin
        seen_adr = wb_adr; seen_dat = wb_dat_o;
        seen_sel = wb_sel; seen_we = wb_we;
      end else if (wb_adr !== seen_adr || wb_dat_o !== seen_dat ||
                   wb_sel !== seen_sel || wb_we !== seen_we) begin
        unstable = 1;
      end
      slv_cnt = slv_cnt + 1;
      if (slv_cnt >= slv_wait) begin
        wb_ack   <= 1'b1;
        wb_dat_i <= mem[wb_adr[6:3]];
        if (wb_we)
          for (int b = 0; b < 8; b++)
            if (wb_sel[b]) mem[wb_adr[6:3]][8*b +: 8] = wb_dat_o[8*b +: 8];
        slv_ack_cyc = cyc_cnt;
        slv_cnt = 0;
      end
    end else begin
      wb_ack <= 1'b0;
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One debug access; returns read data and the cycle in which ack was seen
  task automatic access(bit wr, logic [1:0] idx, logic [63:0] wd,
                        output logic [63:0] rd, output int ack_cyc);
    int guard = 0;
    @(negedge clk);
    dbg_req = 1; dbg_wr = wr; dbg_addr = idx; dbg_wdata = wd;
    do begin
      @(negedge clk);
      guard++;
    end while (!dbg_ack && guard < 200);
    rd = dbg_rdata;
    ack_cyc = cyc_cnt;
    dbg_req = 0;
    @(negedge clk);
    check(dbg_ack == 1'b0, "R8 ack single cycle", 64'(dbg_ack), 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] rd; int c;
    check(!wb_cyc && !wb_stb && !dbg_ack, "R1 bus idle after reset",
          {wb_cyc, wb_stb, dbg_ack}, 0);
    access(0, 2'd0, '0, rd, c);
    check(rd == 0, "R1 address reset value", rd, 0);
    access(0, 2'd2, '0, rd, c);
    check(rd == 0, "R1 control reset value", rd, 0);
  endtask

  task automatic t_regs();
    logic [63:0] rd; int c;
    access(1, 2'd0, '1, rd, c);
    access(0, 2'd0, '0, rd, c);
    check(rd == '1, "R2 address readback ones", rd, '1);
    access(1, 2'd0, 64'h1234_5678_9ABC_DEF0, rd, c);
    access(0, 2'd0, '0, rd, c);
    check(rd == 64'h1234_5678_9ABC_DEF0, "R2 address readback pattern", rd,
          64'h1234_5678_9ABC_DEF0);
    access(1, 2'd2, '1, rd, c);
    access(0, 2'd2, '0, rd, c);
    check(rd == '1, "R3 control readback ones", rd, '1);
  endtask

  task automatic t_unused();
    logic [63:0] rd; int c;
    access(1, 2'd0, 64'h40, rd, c);
    access(1, 2'd2, 64'h3C5, rd, c);
    access(1, 2'd3, 64'hDEAD_BEEF_0000_FFFF, rd, c);
    access(0, 2'd3, '0, rd, c);
    check(rd == 0, "R10 unused index reads zero", rd, 0);
    access(0, 2'd0, '0, rd, c);
    check(rd == 64'h40, "R10 address untouched", rd, 64'h40);
    access(0, 2'd2, '0, rd, c);
    check(rd == 64'h3C5, "R10 control untouched", rd, 64'h3C5);
  endtask

  task automatic t_burst_read();
    logic [63:0] rd; int c;
    slv_wait = 3;
    access(1, 2'd0, 64'h0, rd, c);
    access(1, 2'd2, 64'h7FF, rd, c);
    for (int k = 0; k < 4; k++) begin
      access(0, 2'd1, '0, rd, c);
      check(rd == init_word(k), "R4 read data", rd, init_word(k));
      check(seen_adr == 64'(8 * k), "R9 step 8 address", seen_adr, 64'(8 * k));
      check(seen_we == 0, "R4 read direction", 64'(seen_we), 0);
      check(c == slv_ack_cyc + 1, "R6 ack after bus ack", 64'(c),
            64'(slv_ack_cyc + 1));
    end
    access(0, 2'd0, '0, rd, c);
    check(rd == 64'h20, "R9 address after burst", rd, 64'h20);
  endtask

  task automatic t_write();
    logic [63:0] rd, exp; int c;
    logic [63:0] wd = 64'hAABB_CCDD_1122_3344;
    slv_wait = 1;
    exp = init_word(5);
    exp[31:0] = wd[31:0];
    access(1, 2'd0, 64'h28, rd, c);
    access(1, 2'd2, 64'h40F, rd, c);
    access(1, 2'd1, wd, rd, c);
    check(seen_we == 1, "R5 write direction", 64'(seen_we), 1);
    check(seen_sel == 8'h0F, "R5 byte selects", 64'(seen_sel), 64'h0F);
    check(seen_dat == wd, "R5 write data", seen_dat, wd);
    check(seen_adr == 64'h28, "R5 write address", seen_adr, 64'h28);
    access(0, 2'd0, '0, rd, c);
    check(rd == 64'h2C, "R9 step 4 after write", rd, 64'h2C);
    access(1, 2'd0, 64'h28, rd, c);
    access(1, 2'd2, 64'h0FF, rd, c);
    access(0, 2'd1, '0, rd, c);
    check(rd == exp, "R5 merged lanes read back", rd, exp);
    access(0, 2'd0, '0, rd, c);
    check(rd == 64'h28, "R9 no step when bit10 clear", rd, 64'h28);
  endtask

  task automatic t_hold();
    logic [63:0] rd; int c;
    slv_wait = 7;
    unstable = 0;
    access(1, 2'd1, 64'h5555_AAAA_5555_AAAA, rd, c);
    check(unstable == 0, "R7 bus fields held", 64'(unstable), 0);
    check(c == slv_ack_cyc + 1, "R6 long stall ack timing", 64'(c),
          64'(slv_ack_cyc + 1));
    check(!wb_cyc, "R7 cycle released after ack", 64'(wb_cyc), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = init_word(i);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_unused();
    t_burst_read();
    t_write();
    t_hold();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule